// File: doc/BRIEF.md
# Mailbox Inbound Message Queue

This block is the receiving end of an inter-core mailbox. Remote cores deliver messages through a single push port. Each message is a channel number and a 64-bit payload. Messages wait in a circular queue until local software consumes them. Software works through a 32-bit register port. It reads the oldest message's channel and its two payload halves, then writes a pop command to drop that message and expose the next one.

The queue does not report a fill count. Software reads the raw read and write slot indices and a separate full flag, and works out the occupancy itself. When the two indices are equal, the full flag tells a full queue from an empty one. The block raises a level interrupt while messages are waiting and the source is unmasked. Software can also reset the queue to empty through a control register.

Top module: `mbx_inbound_fifo`

## Requirements
- R1: After reset, the status register (0x14) reads 0, the interrupt pending register (0x18) reads 0, the mask register (0x1C) reads 0x1F, and `irq` is low.
- R2: A push that is accepted stores the message at the current write index. The oldest stored message reads back at three offsets: its channel, zero-extended, at 0x00, payload bits 31:0 at 0x04, and payload bits 63:32 at 0x08. Messages appear in arrival order. While the queue is empty, all three offsets read 0.
- R3: A push that arrives while the full flag is set is discarded. The indices, the full flag and the stored messages stay unchanged.
- R4: A write to 0x0C with bit 0 set removes the oldest message. A write to 0x0C with bit 0 clear has no effect. A pop while the queue is empty is ignored.
- R5: The status register 0x14 holds the read index in bits 31:24 and the write index in bits 23:16, both zero-extended, and the full flag in bit 2. All other bits read 0.
- R6: Each index steps from DEPTH-1 back to 0. The full flag is set when an accepted push, with no pop in the same cycle, makes the write index equal to the read index. It is cleared by any pop that is taken without a push in the same cycle.
- R7: Register 0x24 reads DEPTH-1.
- R8: Writing the value 0 to 0x10 empties the queue. Both indices return to 0, the full flag and the pending bit clear, and a push in the same cycle is discarded. A nonzero write to 0x10 has no effect.
- R9: The 5-bit mask register at 0x1C can be written and read back. Mask bit 0 at 0 enables the not-empty interrupt.
- R10: The pending bit (0x18 bit 0) is set on the clock edge after any cycle in which the queue holds a message and mask bit 0 is 0. The `irq` output equals the pending bit while mask bit 0 is 0, and is low otherwise.
- R11: Writing 1 to 0x18 bit 0 clears the pending bit, except when the queue held a message and mask bit 0 was 0 in that cycle. In that case the pending bit stays set.
- R12: When a push and a pop happen in the same cycle, both take effect. There are two exceptions. A push in a full cycle is discarded while the pop is still taken. A pop in an empty cycle is ignored while the push is still taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Offer a message this cycle |
| push_chan | input | CHAN_W | Channel number of the offered message |
| push_payload | input | 64 | Payload of the offered message |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Not-empty interrupt |

## Verification
The bench runs the queue up to full and pushes into it, to catch a design that overwrites the oldest message or moves the write index. It pushes and pops in the same cycle at empty, at full and in between, where a design that gets the order wrong loses a message, duplicates one, or sets the full flag. It drives enough traffic for both indices to step past DEPTH-1, so a wrong wrap shows up as a bad status word. It also clears the interrupt while messages remain, and then again once the queue is empty, to expose a clear that drops a live interrupt or one that cannot be cleared at all.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int unsigned REG_W     = 32;
  localparam int unsigned PAYLOAD_W = 64;
  localparam int unsigned MASK_W    = 5;
  localparam int unsigned IDX_FLD_W = 8;

  // Register offsets decoded by software; these values are behaviour.
  localparam logic [5:0] OFS_CHAN   = 6'h00;
  localparam logic [5:0] OFS_LO     = 6'h04;
  localparam logic [5:0] OFS_HI     = 6'h08;
  localparam logic [5:0] OFS_POP    = 6'h0C;
  localparam logic [5:0] OFS_CTRL   = 6'h10;
  localparam logic [5:0] OFS_STAT   = 6'h14;
  localparam logic [5:0] OFS_PEND   = 6'h18;
  localparam logic [5:0] OFS_MASK   = 6'h1C;
  localparam logic [5:0] OFS_DEPTH  = 6'h24;

  localparam int unsigned STAT_FULL_BIT = 2;

  typedef struct packed {
    logic [31:0] hi;
    logic [31:0] lo;
  } mbx_payload_t;

  // Occupancy as software would derive it from the raw indices.
  function automatic logic [8:0] fill_level(input logic [7:0] rd,
                                            input logic [7:0] wr,
                                            input logic       full,
                                            input logic [8:0] depth);
    logic [8:0] lvl;
    if (rd == wr)     lvl = full ? depth : 9'd0;
    else if (wr > rd) lvl = {1'b0, wr} - {1'b0, rd};
    else              lvl = depth - {1'b0, rd} + {1'b0, wr};
    return lvl;
  endfunction

  // Status word: read index high byte, write index next byte, full flag.
  function automatic logic [REG_W-1:0] pack_status(input logic [7:0] rd,
                                                   input logic [7:0] wr,
                                                   input logic       full);
    logic [REG_W-1:0] w;
    w = '0;
    w[31:24] = rd;
    w[23:16] = wr;
    w[STAT_FULL_BIT] = full;
    return w;
  endfunction

endpackage

// File: rtl/mbx_ptr_ctrl.sv
module mbx_ptr_ctrl #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic             flush,
  output logic             do_push,
  output logic             do_pop,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             full,
  output logic             empty
);
  import mbx_pkg::*;

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  logic [PTR_W-1:0] wr_nxt, rd_nxt;
  logic             full_nxt;
  logic [8:0]       level;

  assign empty   = (rd_ptr == wr_ptr) && !full;
  assign do_push = push_req && !full && !flush;
  assign do_pop  = pop_req && !empty && !flush;

  always_comb begin
    wr_nxt   = do_push ? step(wr_ptr) : wr_ptr;
    rd_nxt   = do_pop  ? step(rd_ptr) : rd_ptr;
    full_nxt = full;
    if (do_push && !do_pop)      full_nxt = (step(wr_ptr) == rd_ptr);
    else if (do_pop && !do_push) full_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      full   <= 1'b0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      full   <= 1'b0;
    end else begin
      wr_ptr <= wr_nxt;
      rd_ptr <= rd_nxt;
      full   <= full_nxt;
    end
  end

  assign level = fill_level(8'(rd_ptr), 8'(wr_ptr), full, 9'(DEPTH));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req && !flush) |=> $stable(wr_ptr));
  p_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_req && !flush) |=> $stable(rd_ptr));
  p_full_eq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (rd_ptr == wr_ptr));
  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (wr_ptr == '0 && rd_ptr == '0 && !full));
  p_level_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    level <= 9'(DEPTH));
  p_both_keep_level_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (do_push && do_pop) |=> $stable(level));

endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned PTR_W   = 3,
  parameter int unsigned ENTRY_W = 72
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [PTR_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0] wr_entry,
  input  logic [PTR_W-1:0]   rd_idx,
  output logic [ENTRY_W-1:0] rd_entry
);

  logic [ENTRY_W-1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    slot[g] <= '0;
      else if (wr_en && wr_idx == PTR_W'(g))         slot[g] <= wr_entry;
    end
  end

  always_comb begin
    rd_entry = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rd_idx == PTR_W'(i)) rd_entry = slot[i];
  end

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl #(
  parameter int unsigned MASK_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_we,
  input  logic [MASK_W-1:0] mask_wdata,
  input  logic              clr_req,
  input  logic              flush,
  input  logic              has_data,
  output logic [MASK_W-1:0] mask_q,
  output logic              pend_q,
  output logic              irq
);

  logic src_live;

  assign src_live = has_data && !mask_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      pend_q <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      if (flush)         pend_q <= 1'b0;
      else if (src_live) pend_q <= 1'b1;
      else if (clr_req)  pend_q <= 1'b0;
    end
  end

  assign irq = pend_q && !mask_q[0];

  p_pend_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (has_data && !mask_q[0] && !flush) |=> pend_q);
  p_clear_works_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && clr_req && !has_data && !flush) |=> !pend_q);
  p_flush_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !pend_q);

endmodule

// File: rtl/mbx_inbound_fifo.sv
module mbx_inbound_fifo #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned CHAN_W = 8,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [CHAN_W-1:0] push_chan,
  input  logic [63:0]       push_payload,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wen,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  import mbx_pkg::*;

  localparam int unsigned PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned ENTRY_W = CHAN_W + PAYLOAD_W;

  if (DEPTH < 2 || DEPTH > 256) begin : g_bad_depth
    $error("DEPTH must lie in 2..256");
  end
  if (ADDR_W != 6) begin : g_bad_addr
    $error("ADDR_W must be 6");
  end

  logic             wr_pop, wr_flush, wr_clr, wr_mask;
  logic             do_push, do_pop, full, empty;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [ENTRY_W-1:0] head, new_entry;
  logic [MASK_W-1:0]  mask_q;
  logic               pend_q;
  logic [CHAN_W-1:0]  head_chan;
  mbx_payload_t       head_pl;

  // Register write decode.
  assign wr_pop   = reg_wen && reg_addr == OFS_POP  && reg_wdata[0];
  assign wr_flush = reg_wen && reg_addr == OFS_CTRL && reg_wdata == '0;
  assign wr_clr   = reg_wen && reg_addr == OFS_PEND && reg_wdata[0];
  assign wr_mask  = reg_wen && reg_addr == OFS_MASK;

  assign new_entry = {push_chan, push_payload};

  mbx_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (push_valid),
    .pop_req  (wr_pop),
    .flush    (wr_flush),
    .do_push  (do_push),
    .do_pop   (do_pop),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .full     (full),
    .empty    (empty)
  );

  mbx_store #(.DEPTH(DEPTH), .PTR_W(PTR_W), .ENTRY_W(ENTRY_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (do_push),
    .wr_idx   (wr_ptr),
    .wr_entry (new_entry),
    .rd_idx   (rd_ptr),
    .rd_entry (head)
  );

  mbx_irq_ctrl #(.MASK_W(MASK_W)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mask_we    (wr_mask),
    .mask_wdata (reg_wdata[MASK_W-1:0]),
    .clr_req    (wr_clr),
    .flush      (wr_flush),
    .has_data   (!empty),
    .mask_q     (mask_q),
    .pend_q     (pend_q),
    .irq        (irq)
  );

  assign head_chan = empty ? '0 : head[ENTRY_W-1 -: CHAN_W];
  assign head_pl   = empty ? '0 : mbx_payload_t'(head[PAYLOAD_W-1:0]);

  always_comb begin
    unique case (reg_addr)
      OFS_CHAN:  reg_rdata = 32'(head_chan);
      OFS_LO:    reg_rdata = head_pl.lo;
      OFS_HI:    reg_rdata = head_pl.hi;
      OFS_STAT:  reg_rdata = pack_status(8'(rd_ptr), 8'(wr_ptr), full);
      OFS_PEND:  reg_rdata = {31'd0, pend_q};
      OFS_MASK:  reg_rdata = 32'(mask_q);
      OFS_DEPTH: reg_rdata = 32'(DEPTH - 1);
      default:   reg_rdata = '0;
    endcase
  end

  p_empty_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && reg_addr == OFS_CHAN) |-> (reg_rdata == '0));
  p_irq_only_with_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend_q && !mask_q[0]));

endmodule

// File: tb/mbx_inbound_fifo_tb.sv
module mbx_inbound_fifo_tb;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 1'b0;
  logic [7:0]  push_chan = '0;
  logic [63:0] push_payload = '0;
  logic [5:0]  reg_addr = '0;
  logic        reg_wen = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  always #2 clk = ~clk;

  mbx_inbound_fifo #(.DEPTH(DEPTH), .CHAN_W(8), .ADDR_W(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_chan(push_chan),
    .push_payload(push_payload), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  int ntests = 0;
  int nfail  = 0;
  bit done   = 0;

  // Behavioural reference.
  bit [71:0] q[$];
  int        rdp = 0, wrp = 0;
  bit [4:0]  m_mask = 5'h1F;
  bit        m_pend = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    ntests++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic bit [31:0] exp_reg(input bit [5:0] a);
    bit [31:0] v = 0;
    case (a)
      6'h00: v = (q.size() > 0) ? {24'd0, q[0][71:64]} : 0;
      6'h04: v = (q.size() > 0) ? q[0][31:0] : 0;
      6'h08: v = (q.size() > 0) ? q[0][63:32] : 0;
      6'h14: begin
        v[31:24] = rdp[7:0];
        v[23:16] = wrp[7:0];
        v[2]     = (q.size() == DEPTH);
      end
      6'h18: v = {31'd0, m_pend};
      6'h1C: v = {27'd0, m_mask};
      6'h24: v = DEPTH - 1;
      default: v = 0;
    endcase
    return v;
  endfunction

  task automatic model_step(input bit push, input bit [7:0] ch, input bit [63:0] pl,
                            input bit wen, input bit [5:0] a, input bit [31:0] wd);
    bit flush = wen && a == 6'h10 && wd == 0;
    bit pop   = wen && a == 6'h0C && wd[0];
    bit clrp  = wen && a == 6'h18 && wd[0];
    bit had   = q.size() > 0;
    bit mfull = q.size() == DEPTH;
    if (flush)                  m_pend = 0;
    else if (had && !m_mask[0]) m_pend = 1;
    else if (clrp)              m_pend = 0;
    if (wen && a == 6'h1C) m_mask = wd[4:0];
    if (flush) begin
      q.delete();
      rdp = 0;
      wrp = 0;
    end else begin
      if (pop && had) begin
        void'(q.pop_front());
        rdp = (rdp + 1) % DEPTH;
      end
      if (push && !mfull) begin
        q.push_back({ch, pl});
        wrp = (wrp + 1) % DEPTH;
      end
    end
  endtask

  task automatic cyc(input bit push, input bit [7:0] ch, input bit [63:0] pl,
                     input bit wen, input bit [5:0] a, input bit [31:0] wd);
    @(negedge clk);
    push_valid = push; push_chan = ch; push_payload = pl;
    reg_wen = wen; reg_addr = a; reg_wdata = wd;
    @(posedge clk);
    model_step(push, ch, pl, wen, a, wd);
  endtask

  task automatic rd_chk(input bit [5:0] a, input string tag);
    @(negedge clk);
    push_valid = 0; reg_wen = 0; reg_wdata = 0; reg_addr = a;
    #1 chk(tag, reg_rdata, exp_reg(a));
    @(posedge clk);
    model_step(0, 0, 0, 0, a, 0);
  endtask

  task automatic push_msg(input bit [7:0] ch, input bit [63:0] pl);
    cyc(1, ch, pl, 0, 6'h00, 0);
  endtask

  task automatic reg_wr(input bit [5:0] a, input bit [31:0] wd);
    cyc(0, 0, 0, 1, a, wd);
  endtask

  task automatic check_head(input string tag);
    rd_chk(6'h00, tag);
    rd_chk(6'h04, tag);
    rd_chk(6'h08, tag);
    rd_chk(6'h14, tag);
  endtask

  // R10: irq compared with the model on every clock.
  always @(negedge clk) begin
    if (rst_n && !done) chk("R10 irq", {31'd0, irq}, {31'd0, m_pend && !m_mask[0]});
  end

  initial begin
    #400000;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state, R7 depth
    rd_chk(6'h14, "R1 status");
    rd_chk(6'h18, "R1 pending");
    rd_chk(6'h1C, "R1 mask");
    chk("R1 mask literal", exp_reg(6'h1C), 32'h1F);
    rd_chk(6'h24, "R7 depth");
    chk("R7 depth literal", exp_reg(6'h24), 32'd7);
    rd_chk(6'h00, "R2 empty chan");
    rd_chk(6'h08, "R2 empty hi");

    // R2 arrival order; masked so no pending (R10)
    push_msg(8'h11, 64'hAAAA_0001_5555_0001);
    push_msg(8'h22, 64'hAAAA_0002_5555_0002);
    push_msg(8'h33, 64'hAAAA_0003_5555_0003);
    check_head("R2 head");
    rd_chk(6'h18, "R10 masked");

    // R9 mask write, R10 pending rises
    reg_wr(6'h1C, 32'h0000_001E);
    rd_chk(6'h1C, "R9 mask readback");
    rd_chk(6'h18, "R10 pending set");

    // R11 clear while data remains keeps pending
    reg_wr(6'h18, 32'h1);
    rd_chk(6'h18, "R11 clear held");

    // R4 pop with bit0 clear ignored, bit0 set pops
    reg_wr(6'h0C, 32'h2);
    check_head("R4 no pop");
    reg_wr(6'h0C, 32'h1);
    check_head("R4 pop");
    reg_wr(6'h0C, 32'h1);
    reg_wr(6'h0C, 32'h1);
    check_head("R4 drained");
    reg_wr(6'h0C, 32'h1);
    check_head("R4 pop empty");

    // R11 clear once empty
    reg_wr(6'h18, 32'h1);
    rd_chk(6'h18, "R11 clear empty");

    // R6 fill to full, R3 overflow dropped
    for (int i = 0; i < DEPTH; i++) push_msg(8'(8'h40 + i), {32'(i), 32'(~i)});
    rd_chk(6'h14, "R6 full status");
    chk("R6 full bit", exp_reg(6'h14) & 32'h4, 32'h4);
    push_msg(8'hEE, 64'hDEAD_BEEF_DEAD_BEEF);
    check_head("R3 overflow dropped");

    // R12 push+pop at full: pop taken, push dropped
    cyc(1, 8'h99, 64'h9, 1, 6'h0C, 32'h1);
    check_head("R12 full both");
    // R12 push+pop in the middle
    cyc(1, 8'h77, 64'h7, 1, 6'h0C, 32'h1);
    check_head("R12 mid both");

    // R5/R6 wrap: pops and pushes run the indices around
    for (int i = 0; i < 2 * DEPTH + 3; i++) begin
      cyc(1, 8'(i), {32'(i * 3), 32'(i)}, 1, 6'h0C, 32'h1);
      rd_chk(6'h14, "R5 status wrap");
    end
    for (int i = 0; i < DEPTH; i++) reg_wr(6'h0C, 32'h1);
    check_head("R6 drained after wrap");

    // R12 push+pop when empty: push taken
    cyc(1, 8'h5A, 64'h1234_5678_9ABC_DEF0, 1, 6'h0C, 32'h1);
    check_head("R12 empty both");

    // R8 nonzero ctrl write ignored, zero flushes and drops push
    push_msg(8'h61, 64'h61);
    reg_wr(6'h10, 32'h1);
    check_head("R8 nonzero ignored");
    cyc(1, 8'h62, 64'h62, 1, 6'h10, 32'h0);
    check_head("R8 flush");
    rd_chk(6'h18, "R8 pending cleared");
    chk("R8 status zero", exp_reg(6'h14), 32'h0);

    // R9 re-mask: irq drops, pending still readable
    push_msg(8'h70, 64'h70);
    rd_chk(6'h18, "R10 pend again");
    reg_wr(6'h1C, 32'h1F);
    rd_chk(6'h1C, "R9 mask all");
    reg_wr(6'h18, 32'h1);
    rd_chk(6'h18, "R11 clear when masked");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

endmodule